// File: doc/BRIEF.md
# Hybrid Static/Dynamic Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a small direct-mapped table of tagged entries, each holding a 2-bit saturating confidence counter. A branch that has an entry is predicted from the top bit of its counter. A branch without an entry falls back to a fixed rule based on the sign of its displacement: a backward branch, usually a loop, is guessed taken, and a forward branch is guessed not taken.

The fetch stage presents a branch PC and its displacement sign on the lookup side. It gets a prediction, a hit flag and the counter value in the same cycle. The resolve stage later reports the branch PC, its real direction, its displacement sign and whether the earlier prediction was wrong. An entry that hits is trained toward the outcome. A branch that misses gets an entry only when the static rule turned out wrong, so branches that the rule already handles use no table space.

Top module: `brdir_predictor`

## Requirements
- R1: A lookup hits only if the entry at index PC[IDX_W+1:2] is valid and holds the tag PC[PC_W-1:IDX_W+2]. Two PCs with the same index and different tags never hit on each other's entry.
- R2: On a hit, `lk_ctr` shows the entry's counter and `lk_taken` is its top bit: 2 and 3 mean taken, 0 and 1 mean not taken.
- R3: On a miss, `lk_taken` equals `lk_backward` (1 = backward displacement) and `lk_ctr` reads 0.
- R4: An update that hits with `up_taken`=1 raises the counter by one, and it stays at 3 once it is there.
- R5: An update that hits with `up_taken`=0 lowers the counter by one, and it stays at 0 once it is there.
- R6: An update that misses, with `up_mispred`=1 and an outcome opposite to the static guess for `up_backward`, writes the entry at its index. The write sets the valid bit and the new tag and replaces any previous occupant. The counter is set to 2 if the branch was taken and to 1 if it was not.
- R7: An update that misses allocates nothing when `up_mispred`=0, or when the outcome agrees with the static guess.
- R8: Table changes appear at the clock edge that ends the update cycle. A lookup of the same entry in that cycle still sees the old contents.
- R9: While `rst_n` is low, every valid bit is cleared. After reset, every branch uses the static rule until it is allocated.
- R10: With `up_valid` low, the table does not change, whatever the other update inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lk_pc | input | PC_W | PC of the branch being looked up |
| lk_backward | input | 1 | 1 when the looked-up branch has a negative displacement |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hit | output | 1 | 1 when the prediction came from a table entry |
| lk_ctr | output | 2 | Counter of the hit entry, 0 on a miss |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Real direction of the resolved branch |
| up_backward | input | 1 | 1 when the resolved branch has a negative displacement |
| up_mispred | input | 1 | 1 when the earlier prediction for this branch was wrong |

## Verification
The bench uses the default parameters: a 32-bit PC and IDX_W=4, which gives 16 entries. With that size, two PCs 0x1000 bytes apart share index 4, so eviction by an aliasing branch (R1, R6) can be reached. A loop with five taken iterations and a not-taken exit, together with a forward branch that is nearly always taken, drives counters to both saturation limits.

Same-cycle lookup and update of one PC checks that a lookup sees the old contents (R8). A mispredicted miss whose outcome agrees with the static rule checks that nothing is allocated (R7).

// File: rtl/brdir_pkg.sv
package brdir_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_MAX    = '1;
  localparam ctr_t CTR_WEAK_T = ctr_t'(1 << (CTR_W - 1));
  localparam ctr_t CTR_WEAK_N = ctr_t'((1 << (CTR_W - 1)) - 1);
endpackage

// File: rtl/brdir_ctr_sat.sv
module brdir_ctr_sat
  import brdir_pkg::*;
(
  input  ctr_t cur,
  input  logic taken,
  output ctr_t nxt
);
  always_comb begin
    nxt = cur;
    if (taken) begin
      if (cur != CTR_MAX) nxt = cur + ctr_t'(1);
    end else begin
      if (cur != '0) nxt = cur - ctr_t'(1);
    end
  end
endmodule

// File: rtl/brdir_static_rule.sv
module brdir_static_rule (
  input  logic backward,
  output logic guess_taken
);
  // backward displacement: loop closing branch, guess taken
  assign guess_taken = backward;
endmodule

// File: rtl/brdir_table.sv
module brdir_table
  import brdir_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  ctr_t             wr_ctr,
  input  logic [IDX_W-1:0] ra_idx,
  output logic             ra_valid,
  output logic [TAG_W-1:0] ra_tag,
  output ctr_t             ra_ctr,
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_valid,
  output logic [TAG_W-1:0] rb_tag,
  output ctr_t             rb_ctr
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] v_arr;
  logic [TAG_W-1:0] t_arr [DEPTH];
  ctr_t             c_arr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic             ent_we;
    logic             valid_q, valid_d;
    logic [TAG_W-1:0] tag_q;
    ctr_t             ctr_q;

    assign ent_we = wr_en && (wr_idx == IDX_W'(i));

    always_comb begin
      valid_d = valid_q;
      if (ent_we) valid_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (ent_we) begin
        tag_q <= wr_tag;
        ctr_q <= wr_ctr;
      end
    end

    assign v_arr[i] = valid_q;
    assign t_arr[i] = tag_q;
    assign c_arr[i] = ctr_q;
  end

  assign ra_valid = v_arr[ra_idx];
  assign ra_tag   = t_arr[ra_idx];
  assign ra_ctr   = c_arr[ra_idx];
  assign rb_valid = v_arr[rb_idx];
  assign rb_tag   = t_arr[rb_idx];
  assign rb_ctr   = c_arr[rb_idx];
endmodule

// File: rtl/brdir_predictor.sv
module brdir_predictor
  import brdir_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_backward,
  output logic            lk_taken,
  output logic            lk_hit,
  output logic [1:0]      lk_ctr,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_backward,
  input  logic            up_mispred
);
  localparam int TAG_LO = IDX_W + 2;
  localparam int TAG_W  = PC_W - TAG_LO;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;

  assign lk_idx = lk_pc[TAG_LO-1:2];
  assign lk_tag = lk_pc[PC_W-1:TAG_LO];
  assign up_idx = up_pc[TAG_LO-1:2];
  assign up_tag = up_pc[PC_W-1:TAG_LO];

  logic             unused_low_bits;
  assign unused_low_bits = ^{lk_pc[1:0], up_pc[1:0]};

  logic             a_valid, b_valid;
  logic [TAG_W-1:0] a_tag, b_tag;
  ctr_t             a_ctr, b_ctr;
  logic             wr_en;
  ctr_t             wr_ctr;

  brdir_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (up_idx),
    .wr_tag  (up_tag),
    .wr_ctr  (wr_ctr),
    .ra_idx  (lk_idx),
    .ra_valid(a_valid),
    .ra_tag  (a_tag),
    .ra_ctr  (a_ctr),
    .rb_idx  (up_idx),
    .rb_valid(b_valid),
    .rb_tag  (b_tag),
    .rb_ctr  (b_ctr)
  );

  // lookup side
  logic lk_static;
  logic lk_match;

  brdir_static_rule i_lk_static (.backward(lk_backward), .guess_taken(lk_static));

  assign lk_match = a_valid && (a_tag == lk_tag);

  always_comb begin
    lk_hit   = lk_match;
    lk_taken = lk_static;
    lk_ctr   = '0;
    if (lk_match) begin
      lk_taken = a_ctr[CTR_W-1];
      lk_ctr   = a_ctr;
    end
  end

  // update side
  logic up_static;
  logic up_match;
  ctr_t trained;

  brdir_static_rule i_up_static (.backward(up_backward), .guess_taken(up_static));
  brdir_ctr_sat     i_sat       (.cur(b_ctr), .taken(up_taken), .nxt(trained));

  assign up_match = b_valid && (b_tag == up_tag);

  always_comb begin
    wr_en  = 1'b0;
    wr_ctr = trained;
    if (up_valid) begin
      if (up_match) begin
        wr_en = 1'b1;
      end else if (up_mispred && (up_static != up_taken)) begin
        wr_en  = 1'b1;
        wr_ctr = up_taken ? CTR_WEAK_T : CTR_WEAK_N;
      end
    end
  end
endmodule

// File: rtl/brdir_checker.sv
module brdir_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] lk_pc,
  input logic            lk_backward,
  input logic            lk_taken,
  input logic            lk_hit,
  input logic [1:0]      lk_ctr,
  input logic            up_valid,
  input logic [PC_W-1:0] up_pc,
  input logic            up_taken,
  input logic            up_backward,
  input logic            up_mispred
);
  // R2
  hit_uses_ctr_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_taken == lk_ctr[1]));

  // R3
  miss_static_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_taken == lk_backward && lk_ctr == 2'd0));

  // R4
  taken_inc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && lk_hit && up_pc == lk_pc) |=>
      ((lk_pc != $past(lk_pc)) ||
       (lk_hit && lk_ctr == (($past(lk_ctr) == 2'd3) ? 2'd3 : 2'($past(lk_ctr) + 2'd1)))));

  // R5
  ntaken_dec_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && lk_hit && up_pc == lk_pc) |=>
      ((lk_pc != $past(lk_pc)) ||
       (lk_hit && lk_ctr == (($past(lk_ctr) == 2'd0) ? 2'd0 : 2'($past(lk_ctr) - 2'd1)))));

  // R6
  alloc_weak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_mispred && (up_backward != up_taken) && !lk_hit && up_pc == lk_pc) |=>
      ((lk_pc != $past(lk_pc)) ||
       (lk_hit && lk_ctr == ($past(up_taken) ? 2'd2 : 2'd1))));

  // R7
  no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && (!up_mispred || up_backward == up_taken) && !lk_hit && up_pc == lk_pc) |=>
      ((lk_pc != $past(lk_pc)) || !lk_hit));

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> !lk_hit);
endmodule

bind brdir_predictor brdir_checker #(.PC_W(PC_W)) i_brdir_checker (
  .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_backward(lk_backward),
  .lk_taken(lk_taken), .lk_hit(lk_hit), .lk_ctr(lk_ctr), .up_valid(up_valid),
  .up_pc(up_pc), .up_taken(up_taken), .up_backward(up_backward),
  .up_mispred(up_mispred)
);

// File: tb/test_brdir_predictor.sv
`timescale 1ns/1ps
module test_brdir_predictor;
  localparam int PC_W   = 32;
  localparam int IDX_W  = 4;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int TAG_LO = IDX_W + 2;
  localparam int TAG_W  = PC_W - TAG_LO;

  logic            clk;
  logic            rst_n;
  logic [PC_W-1:0] lk_pc;
  logic            lk_backward;
  logic            lk_taken;
  logic            lk_hit;
  logic [1:0]      lk_ctr;
  logic            up_valid;
  logic [PC_W-1:0] up_pc;
  logic            up_taken;
  logic            up_backward;
  logic            up_mispred;

  brdir_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) i_brdir_predictor (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_backward(lk_backward),
    .lk_taken(lk_taken), .lk_hit(lk_hit), .lk_ctr(lk_ctr), .up_valid(up_valid),
    .up_pc(up_pc), .up_taken(up_taken), .up_backward(up_backward),
    .up_mispred(up_mispred)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model
  bit               m_v   [DEPTH];
  logic [TAG_W-1:0] m_tag [DEPTH];
  logic [1:0]       m_c   [DEPTH];

  function automatic int m_idx(logic [PC_W-1:0] pc);
    return int'(pc[TAG_LO-1:2]);
  endfunction

  function automatic bit m_hit(logic [PC_W-1:0] pc);
    return m_v[m_idx(pc)] && (m_tag[m_idx(pc)] == pc[PC_W-1:TAG_LO]);
  endfunction

  function automatic bit m_pred(logic [PC_W-1:0] pc, bit back);
    return m_hit(pc) ? m_c[m_idx(pc)][1] : back;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
  endtask

  task automatic m_update(logic [PC_W-1:0] pc, bit t, bit back, bit mis);
    int k;
    k = m_idx(pc);
    if (m_hit(pc)) begin
      if (t && m_c[k] != 2'd3) m_c[k] = m_c[k] + 2'd1;
      else if (!t && m_c[k] != 2'd0) m_c[k] = m_c[k] - 2'd1;
    end else if (mis && (back != t)) begin
      m_v[k]   = 1;
      m_tag[k] = pc[PC_W-1:TAG_LO];
      m_c[k]   = t ? 2'd2 : 2'd1;
    end
  endtask

  // scoreboard
  logic [3:0] exp_q [$];
  string      req_q [$];

  task automatic drive(logic [PC_W-1:0] lpc, bit lback, bit uv,
                       logic [PC_W-1:0] upc, bit ut, bit ub, bit um, string req);
    bit h;
    @(posedge clk);
    #1;
    lk_pc = lpc; lk_backward = lback;
    up_valid = uv; up_pc = upc; up_taken = ut; up_backward = ub; up_mispred = um;
    h = rst_n ? m_hit(lpc) : 1'b0;
    exp_q.push_back({(h ? m_c[m_idx(lpc)][1] : lback), h, (h ? m_c[m_idx(lpc)] : 2'd0)});
    req_q.push_back(req);
    if (uv && rst_n) m_update(upc, ut, ub, um);
  endtask

  task automatic look(logic [PC_W-1:0] pc, bit back, string req);
    drive(pc, back, 1'b0, '0, 1'b0, 1'b0, 1'b0, req);
  endtask

  // lookup and resolve the same branch in one cycle
  task automatic branch(logic [PC_W-1:0] pc, bit back, bit outcome, string req);
    bit mis;
    mis = (m_pred(pc, back) != outcome);
    drive(pc, back, 1'b1, pc, outcome, back, mis, req);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      checks++;
      if ({lk_taken, lk_hit, lk_ctr} !== e) begin
        fails++;
        $display("FAIL %s: got taken=%b hit=%b ctr=%0d, expected taken=%b hit=%b ctr=%0d",
                 r, lk_taken, lk_hit, lk_ctr, e[3], e[2], e[1:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  localparam logic [PC_W-1:0] PC_LOOP  = 32'h0000_1010; // index 4
  localparam logic [PC_W-1:0] PC_ALIAS = 32'h0000_2010; // index 4, other tag
  localparam logic [PC_W-1:0] PC_IF    = 32'h0000_1024; // index 9
  localparam logic [PC_W-1:0] PC_FWD   = 32'h0000_3040; // index 0

  initial begin
    rst_n = 1'b0;
    lk_pc = '0; lk_backward = 0;
    up_valid = 0; up_pc = '0; up_taken = 0; up_backward = 0; up_mispred = 0;
    m_clear();
    // R9: lookups under reset miss and use the static rule
    look(PC_LOOP, 1'b1, "R9");
    look(PC_IF, 1'b0, "R9");
    @(posedge clk); #1; rst_n = 1'b1;

    // R3: static rule on misses
    look(PC_LOOP, 1'b1, "R3");
    look(PC_IF, 1'b0, "R3");

    // R7: correctly predicted miss does not allocate
    branch(PC_FWD, 1'b0, 1'b0, "R7");
    look(PC_FWD, 1'b0, "R7");
    // R7: mispredict flag with outcome matching static guess does not allocate
    drive(PC_FWD, 1'b0, 1'b1, PC_FWD, 1'b0, 1'b0, 1'b1, "R7");
    look(PC_FWD, 1'b0, "R7");

    // R4 R6 R8: loop pattern, five taken iterations and an exit, three times
    for (int rep = 0; rep < 3; rep++) begin
      for (int it = 0; it < 5; it++) branch(PC_LOOP, 1'b1, 1'b1, "R4");
      branch(PC_LOOP, 1'b1, 1'b0, "R6");
      look(PC_LOOP, 1'b1, "R8");
    end

    // R2 R4 R6: forward if-branch nearly always taken
    branch(PC_IF, 1'b0, 1'b1, "R6");
    look(PC_IF, 1'b0, "R6");
    for (int it = 0; it < 6; it++) branch(PC_IF, 1'b0, 1'b1, "R4");
    branch(PC_IF, 1'b0, 1'b0, "R2");
    branch(PC_IF, 1'b0, 1'b1, "R2");
    look(PC_IF, 1'b0, "R4");

    // R5: drive to zero and beyond
    for (int it = 0; it < 5; it++) branch(PC_IF, 1'b0, 1'b0, "R5");
    look(PC_IF, 1'b0, "R5");

    // R10: update inputs with up_valid low change nothing
    drive(PC_IF, 1'b0, 1'b0, PC_IF, 1'b1, 1'b0, 1'b1, "R10");
    drive(PC_ALIAS, 1'b0, 1'b0, PC_ALIAS, 1'b1, 1'b0, 1'b1, "R10");
    look(PC_IF, 1'b0, "R10");
    look(PC_ALIAS, 1'b0, "R10");

    // R1: aliasing branch misses, then evicts the loop entry
    look(PC_LOOP, 1'b1, "R1");
    look(PC_ALIAS, 1'b0, "R1");
    branch(PC_ALIAS, 1'b0, 1'b1, "R1");
    look(PC_ALIAS, 1'b0, "R6");
    look(PC_LOOP, 1'b1, "R1");

    // R8: lookup of one PC while another entry is updated
    drive(PC_IF, 1'b0, 1'b1, PC_ALIAS, 1'b1, 1'b0, 1'b0, "R8");
    look(PC_ALIAS, 1'b0, "R8");

    // R9: reset mid-run clears all entries
    @(posedge clk); #1; rst_n = 1'b0; m_clear();
    look(PC_ALIAS, 1'b0, "R9");
    @(posedge clk); #1; rst_n = 1'b1;
    look(PC_ALIAS, 1'b0, "R9");
    look(PC_IF, 1'b0, "R9");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule